// File: doc/BRIEF.md
# Shared Parallel Bus Arbiter with Idle-Grant Lockout

This block is the central arbiter of a parallel shared bus with several request/grant pairs. At every rising clock edge it samples one request line per master together with the bus-status lines FRAME and IRDY. It drives exactly one grant line at a time. When no master is eligible it parks the grant on a master chosen by a select input. Requesters are served in round-robin order. The grant moves only while FRAME is negated, and every hand-over from one master to another passes through one clock with no grant.

A switchable protection covers masters that request the bus but never use it. With the protection on, a requesting master that holds the grant on an idle bus for 16 clocks without asserting FRAME loses the grant. That master is then locked out until its request has been seen low for at least one edge. With the protection off, a granted requester keeps the grant until it starts a transaction or withdraws its request. The arbiter needs only its clock, so it keeps working in any low-power state that leaves the clock running.

All inputs and outputs are active-high: a 1 on `req_i[i]`, `frame_i`, `irdy_i` or `gnt_o[i]` means asserted. Any conversion to the bus's active-low pins happens outside this block.

Top module: `pci_arbiter`

## Requirements
- R1: While `rst_ni` is low, `gnt_o` is all zeros.
- R2: At most one bit of `gnt_o` is 1 in any cycle.
- R3: The grant never moves straight from one master to another. A change always passes through at least one cycle in which `gnt_o` is all zeros.
- R4: When no master is eligible (requesting and not locked out), the grant goes to bit `park_sel_i` of `gnt_o`, provided that master is not locked out.
- R5: Once the owner has asserted `frame_i` while granted and `frame_i` is then seen negated, the next grant goes to the first eligible master in increasing index order after the owner, wrapping from N-1 to 0.
- R6: In any cycle that samples `frame_i` high, `gnt_o` does not change at that edge.
- R7: With `bm_en_i`=1, a requesting owner that has not asserted `frame_i` keeps the grant for 16 idle-bus cycles (`frame_i`=0 and `irdy_i`=0). The grant is then removed, so `gnt_o` is zero after the 16th edge following the grant edge.
- R8: A master whose grant was removed under R7 is not granted again, and not parked on either, until an edge samples its `req_i` bit low. If the park master is locked out and nobody is eligible, `gnt_o` stays zero.
- R9: With `bm_en_i`=0, a requesting owner that has not asserted `frame_i` keeps its grant indefinitely, even while other masters request.
- R10: When the owner negates its request before using the bus, the grant moves to the next eligible master or to the park master, through the zero cycle of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_MASTERS | Request per master, 1 = requesting |
| frame_i | input | 1 | Bus FRAME status, 1 = asserted |
| irdy_i | input | 1 | Bus IRDY status, 1 = asserted |
| park_sel_i | input | $clog2(N_MASTERS) | Index of the master that receives the grant when nobody is eligible |
| bm_en_i | input | 1 | 1 enables the idle-grant lockout protection |
| gnt_o | output | N_MASTERS | Grant per master, at most one bit set |

## Verification
The round-robin function is driven in three ways: with all four masters requesting and each owner running a one-cycle FRAME, with a single requester alternating against the park master, and with a competing request that arrives while the owner holds FRAME. The first pattern separates true rotation and wrap-around from fixed priority. The second separates parking from holding. The third shows that a grant is frozen during FRAME and only moves once FRAME is released. Protection is driven with an idle owner both with and without the enable. The grant must drop at exactly the 16th edge, and the locked master is then placed at the park index, which tells a lockout that also blocks parking apart from one that only blocks arbitration.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_DROP   = 2'd1,
    ACT_GRANT  = 2'd2,
    ACT_REVOKE = 2'd3
  } gnt_act_e;
endpackage

// File: rtl/pci_arb_rr.sv
module pci_arb_rr #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  eligible_i,
  input  logic [IW-1:0] last_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // descending offset so the nearest successor of last_i wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int off = N; off >= 1; off--) begin
      automatic int c = (int'(last_i) + off) % N;
      if (eligible_i[c]) begin
        valid_o = 1'b1;
        idx_o   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/pci_arb_lockout.sv
module pci_arb_lockout #(
  parameter int N          = 4,
  parameter int IW         = 2,
  parameter int IDLE_LIMIT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          bus_idle_i,
  input  logic          bm_en_i,
  input  logic          own_valid_i,
  input  logic [IW-1:0] own_idx_i,
  input  logic          own_used_i,
  output logic [N-1:0]  lock_o,
  output logic          revoke_o
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          idle_own;

  assign idle_own = own_valid_i && req_i[own_idx_i] && !own_used_i && bus_idle_i && bm_en_i;
  assign revoke_o = idle_own && (cnt_q == CW'(IDLE_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (!own_valid_i || own_used_i || revoke_o) cnt_q <= '0;
    else if (idle_own)                             cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_lock
    logic lock_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       lock_q <= 1'b0;
      else if (revoke_o && (own_idx_i == IW'(i)))        lock_q <= 1'b1;
      else if (!req_i[i])                                lock_q <= 1'b0;
    end
    assign lock_o[i] = lock_q;

    // R8: a lock persists while the master keeps requesting
    p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && req_i[i]) |=> lock_q);
  end
endmodule

// File: rtl/pci_arb_grant.sv
module pci_arb_grant
  import pci_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  lock_i,
  input  logic          frame_i,
  input  logic          revoke_i,
  input  logic [IW-1:0] park_sel_i,
  output logic [N-1:0]  gnt_o,
  output logic          own_valid_o,
  output logic [IW-1:0] own_idx_o,
  output logic          own_used_o
);
  logic [N-1:0]  gnt_q;
  logic [IW-1:0] last_q;
  logic          used_q;

  logic          rr_valid;
  logic [IW-1:0] rr_idx;
  logic          park_ok;
  logic          tgt_valid;
  logic [IW-1:0] tgt_idx;
  logic [N-1:0]  tgt_vec;
  logic          keep_owner;
  gnt_act_e      act;

  pci_arb_rr #(.N(N), .IW(IW)) u_rr (
    .eligible_i (req_i & ~lock_i),
    .last_i     (last_q),
    .valid_o    (rr_valid),
    .idx_o      (rr_idx)
  );

  always_comb begin
    own_idx_o = '0;
    for (int i = 0; i < N; i++)
      if (gnt_q[i]) own_idx_o = IW'(i);
  end

  assign own_valid_o = |gnt_q;
  assign own_used_o  = used_q;
  assign park_ok     = !lock_i[park_sel_i];
  assign tgt_valid   = rr_valid || park_ok;
  assign tgt_idx     = rr_valid ? rr_idx : park_sel_i;
  assign tgt_vec     = tgt_valid ? (N'(1) << tgt_idx) : '0;
  assign keep_owner  = own_valid_o && req_i[own_idx_o] && !used_q;

  always_comb begin
    if (revoke_i)              act = ACT_REVOKE;
    else if (frame_i)          act = ACT_HOLD;
    else if (keep_owner)       act = ACT_HOLD;
    else if (gnt_q == tgt_vec) act = ACT_HOLD;
    else if (own_valid_o)      act = ACT_DROP;
    else                       act = ACT_GRANT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= IW'(N - 1);
      used_q <= 1'b0;
    end else begin
      case (act)
        ACT_REVOKE, ACT_DROP: begin
          gnt_q  <= '0;
          used_q <= 1'b0;
        end
        ACT_GRANT: begin
          gnt_q  <= tgt_vec;
          last_q <= tgt_idx;
          used_q <= 1'b0;
        end
        default: if (own_valid_o && frame_i) used_q <= 1'b1;
      endcase
    end
  end

  assign gnt_o = gnt_q;

  // R3: a grant is only ever issued from the empty state
  p_grant_from_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_GRANT) |-> (gnt_q == '0));
endmodule

// File: rtl/pci_arbiter.sv
module pci_arbiter #(
  parameter int N_MASTERS  = 4,
  parameter int IDLE_LIMIT = 16,
  localparam int IW        = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 frame_i,
  input  logic                 irdy_i,
  input  logic [IW-1:0]        park_sel_i,
  input  logic                 bm_en_i,
  output logic [N_MASTERS-1:0] gnt_o
);
  logic                 bus_idle;
  logic [N_MASTERS-1:0] lock;
  logic                 revoke;
  logic                 own_valid;
  logic [IW-1:0]        own_idx;
  logic                 own_used;

  assign bus_idle = !frame_i && !irdy_i;

  pci_arb_grant #(.N(N_MASTERS), .IW(IW)) u_grant (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .lock_i      (lock),
    .frame_i     (frame_i),
    .revoke_i    (revoke),
    .park_sel_i  (park_sel_i),
    .gnt_o       (gnt_o),
    .own_valid_o (own_valid),
    .own_idx_o   (own_idx),
    .own_used_o  (own_used)
  );

  pci_arb_lockout #(.N(N_MASTERS), .IW(IW), .IDLE_LIMIT(IDLE_LIMIT)) u_lockout (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .bus_idle_i  (bus_idle),
    .bm_en_i     (bm_en_i),
    .own_valid_i (own_valid),
    .own_idx_i   (own_idx),
    .own_used_i  (own_used),
    .lock_o      (lock),
    .revoke_o    (revoke)
  );

  p_onehot_gnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_dead_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |=> ((gnt_o == '0) || (gnt_o == $past(gnt_o))));

  p_frame_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> $stable(gnt_o));

  p_revoke_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    revoke |=> (gnt_o == '0));

  p_no_locked_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & lock) == '0));
endmodule

// File: tb/pci_arbiter_bench.sv
`timescale 1ns/100ps
module pci_arbiter_bench;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         frame_i = 1'b0;
  logic         irdy_i = 1'b0;
  logic [1:0]   park_sel_i = 2'd2;
  logic         bm_en_i = 1'b1;
  logic [N-1:0] gnt_o;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk_i = ~clk_i;

  pci_arbiter u_pci_arbiter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .frame_i    (frame_i),
    .irdy_i     (irdy_i),
    .park_sel_i (park_sel_i),
    .bm_en_i    (bm_en_i),
    .gnt_o      (gnt_o)
  );

  // monitor: compares the design output against queued expectations
  always @(negedge clk_i) begin
    while (exp_q.size() > 0) begin
      logic [N-1:0] e;
      string        t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (gnt_o !== e) begin
        fails++;
        $display("FAIL %s: gnt_o=%b expected %b", t, gnt_o, e);
      end
    end
  end

  // driver: one clock, then queue the grant expected after that edge
  task automatic tick(input logic [N-1:0] e, input string t);
    @(posedge clk_i);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk_i);
    #1;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk_i);
    checks++;
    if (gnt_o !== '0) begin
      fails++;
      $display("FAIL R1: gnt_o=%b expected 0000 in reset", gnt_o);
    end
    rst_ni = 1'b1;
    #1;

    // R4: parking with no requester
    tick(4'b0100, "R4 park on select");
    // R3/R10: request from 0 moves grant away from park
    req_i = 4'b0001;
    tick(4'b0000, "R3 dead cycle");
    tick(4'b0001, "R10 grant master0");
    // R6: competing request while FRAME held
    frame_i = 1'b1; req_i = 4'b0011;
    tick(4'b0001, "R6 frame freeze");
    tick(4'b0001, "R6 frame freeze");
    frame_i = 1'b0; irdy_i = 1'b1; req_i = 4'b0010;
    tick(4'b0000, "R3 dead cycle");
    tick(4'b0010, "R5 next master1");
    irdy_i = 1'b0;

    // R5: rotation with all requesting
    req_i = 4'b1111;
    frame_i = 1'b1; tick(4'b0010, "R6 hold in frame");
    frame_i = 1'b0; tick(4'b0000, "R3 dead cycle");
    tick(4'b0100, "R5 rotate to 2");
    frame_i = 1'b1; tick(4'b0100, "R6 hold in frame");
    frame_i = 1'b0; tick(4'b0000, "R3 dead cycle");
    tick(4'b1000, "R5 rotate to 3");
    frame_i = 1'b1; tick(4'b1000, "R6 hold in frame");
    frame_i = 1'b0; tick(4'b0000, "R3 dead cycle");
    tick(4'b0001, "R5 wrap to 0");
    frame_i = 1'b1; tick(4'b0001, "R6 hold in frame");
    frame_i = 1'b0; req_i = 4'b0000;
    tick(4'b0000, "R3 dead cycle");
    tick(4'b0100, "R4 back to park");

    // R7: idle owner loses grant after 16 cycles
    req_i = 4'b0001;
    tick(4'b0000, "R3 dead cycle");
    tick(4'b0001, "R7 granted");
    for (int k = 0; k < 15; k++) tick(4'b0001, "R7 within window");
    tick(4'b0000, "R7 revoked");
    // R8: locked master not regranted, park goes elsewhere
    for (int k = 0; k < 4; k++) tick(4'b0100, "R8 locked out");
    req_i = 4'b0000;
    tick(4'b0100, "R8 release edge");
    req_i = 4'b0001;
    tick(4'b0000, "R3 dead cycle");
    tick(4'b0001, "R8 regranted after release");
    park_sel_i = 2'd0;
    for (int k = 0; k < 15; k++) tick(4'b0001, "R7 within window");
    tick(4'b0000, "R7 revoked again");
    for (int k = 0; k < 3; k++) tick(4'b0000, "R8 locked park master");
    req_i = 4'b0000;
    tick(4'b0000, "R8 release edge");
    tick(4'b0001, "R4 park on master0");

    // R9: protection off, idle owner keeps grant
    bm_en_i = 1'b0; req_i = 4'b0011;
    for (int k = 0; k < 40; k++) tick(4'b0001, "R9 hold without protection");
    req_i = 4'b0010;
    tick(4'b0000, "R10 owner withdrew");
    tick(4'b0010, "R10 grant master1");

    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule